// File: doc/BRIEF.md
# Branch Target Address Unit

This unit works out where instruction fetch should go next when a jump or call is decoded. The processor has a 24-bit program address space. The unit supports four target forms. Two are PC-relative, with a 13-bit or a 16-bit signed displacement. One is a full 24-bit absolute target. The last is indirect: the low 16 bits come from one of eight index registers and the high 8 bits come from a separate indirect-jump page register.

For each branch the unit reports a 24-bit target, whether the branch is taken, and whether it is a delayed branch (one with delay slots). The branch condition is resolved outside the unit and arrives as a single bit.

All three outputs are registered and appear one clock after the inputs are presented. Relative targets wrap modulo 2^24. No page register is written by this unit.

Top module: `bta_unit`

## Requirements
- R1: While reset is asserted, and on the first clock after it is released with no branch presented, `tgt_q`, `taken_q` and `delay_q` are all zero.
- R2: `br_kind[1:0]` selects the form: 00 = 13-bit relative, 01 = 16-bit relative, 10 = 24-bit absolute, 11 = indirect. `br_kind[2]` requests a delayed branch. All outputs follow the inputs with exactly one clock of latency.
- R3: For the 13-bit relative form, the target is `br_pc` plus `br_field[12:0]` sign-extended, modulo 2^24. The branch is taken only when `cond_ok` is high, and `delay_q` copies `br_kind[2]`.
- R4: The 16-bit relative form is unconditional. It is taken whenever it is presented, whatever `cond_ok` is. Its target is `br_pc` plus `br_field[15:0]` sign-extended, modulo 2^24, and `delay_q` copies `br_kind[2]`.
- R5: For the absolute form, the target is `br_field[23:0]` and the branch is taken only when `cond_ok` is high. `delay_q` is always 0, even when `br_kind[2]` is 1.
- R6: For the indirect form, the target is `{ij_page, idx_file[16*idx_sel +: 16]}` for any `idx_sel` from 0 to 7. It is taken only when `cond_ok` is high, and `delay_q` copies `br_kind[2]`.
- R7: When a branch is not taken, `tgt_q` and `delay_q` are zero.
- R8: When `br_valid` is low, `taken_q` is low on the next clock, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | A branch instruction is presented this cycle |
| br_pc | input | 24 | Address of the branch instruction |
| br_kind | input | 3 | [1:0] target form, [2] delayed request |
| br_field | input | 24 | Immediate displacement or absolute target |
| idx_sel | input | 3 | Index register chosen for indirect form |
| idx_file | input | 128 | Eight 16-bit index registers, register n at bits 16n+15:16n |
| ij_page | input | 8 | Indirect-jump page register |
| cond_ok | input | 1 | Resolved branch condition |
| tgt_q | output | 24 | Registered branch target |
| taken_q | output | 1 | Registered taken flag |
| delay_q | output | 1 | Registered delayed-branch flag |

## Verification
The assertions check, on every cycle, the rules that hold for every form. A branch that is not taken shows a zero target and no delay flag. An absolute branch never raises the delay flag. A 16-bit relative branch is always taken. A false condition suppresses the conditional forms. An indirect target carries the page register in its upper byte. The exact arithmetic needs the bench's scenarios: sign extension of each displacement width, wrap across the top and bottom of the address space, and the choice among all eight index registers.

// File: rtl/bta_pkg.sv
package bta_pkg;
    typedef enum logic [1:0] {
        BK_REL13 = 2'b00,
        BK_REL16 = 2'b01,
        BK_LONG  = 2'b10,
        BK_IND   = 2'b11
    } bkind_e;
endpackage

// File: rtl/bta_rel_adder.sv
module bta_rel_adder #(
    parameter int AW   = 24,
    parameter int OFFW = 13
) (
    input  logic [AW-1:0]   base,
    input  logic [OFFW-1:0] disp,
    output logic [AW-1:0]   sum
);
    localparam int EXTW = AW - OFFW;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{EXTW{disp[OFFW-1]}}, disp};
        sum      = base + disp_ext;
    end
endmodule

// File: rtl/bta_idx_sel.sv
module bta_idx_sel #(
    parameter int NIDX = 8,
    parameter int IW   = 16,
    localparam int SELW = $clog2(NIDX)
) (
    input  logic [NIDX*IW-1:0] regs,
    input  logic [SELW-1:0]    sel,
    output logic [IW-1:0]      val
);
    logic [IW-1:0] slots [NIDX];

    for (genvar g = 0; g < NIDX; g++) begin : g_slot
        assign slots[g] = regs[g*IW +: IW];
    end

    always_comb begin
        val = slots[sel];
    end
endmodule

// File: rtl/bta_unit.sv
module bta_unit #(
    parameter int AW   = 24,
    parameter int IW   = 16,
    parameter int NIDX = 8,
    parameter int R13W = 13,
    parameter int R16W = 16,
    localparam int SELW = $clog2(NIDX),
    localparam int PGW  = AW - IW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                br_valid,
    input  logic [AW-1:0]       br_pc,
    input  logic [2:0]          br_kind,
    input  logic [AW-1:0]       br_field,
    input  logic [SELW-1:0]     idx_sel,
    input  logic [NIDX*IW-1:0]  idx_file,
    input  logic [PGW-1:0]      ij_page,
    input  logic                cond_ok,
    output logic [AW-1:0]       tgt_q,
    output logic                taken_q,
    output logic                delay_q
);
    import bta_pkg::*;

    typedef struct packed {
        logic [AW-1:0] tgt;
        logic          taken;
        logic          dly;
    } bta_st_t;

    bta_st_t       st_d, st_q;
    bkind_e        kind_d;
    logic [AW-1:0] sum13_d, sum16_d;
    logic [IW-1:0] idx_val_d;

    bta_rel_adder #(.AW(AW), .OFFW(R13W)) u_add13 (
        .base(br_pc), .disp(br_field[R13W-1:0]), .sum(sum13_d)
    );

    bta_rel_adder #(.AW(AW), .OFFW(R16W)) u_add16 (
        .base(br_pc), .disp(br_field[R16W-1:0]), .sum(sum16_d)
    );

    bta_idx_sel #(.NIDX(NIDX), .IW(IW)) u_idx (
        .regs(idx_file), .sel(idx_sel), .val(idx_val_d)
    );

    always_comb begin
        st_d   = '0;
        kind_d = bkind_e'(br_kind[1:0]);
        if (br_valid) begin
            unique case (kind_d)
                BK_REL13: begin
                    if (cond_ok) begin
                        st_d.taken = 1'b1;
                        st_d.tgt   = sum13_d;
                        st_d.dly   = br_kind[2];
                    end
                end
                BK_REL16: begin
                    st_d.taken = 1'b1;
                    st_d.tgt   = sum16_d;
                    st_d.dly   = br_kind[2];
                end
                BK_LONG: begin
                    if (cond_ok) begin
                        st_d.taken = 1'b1;
                        st_d.tgt   = br_field;
                        st_d.dly   = 1'b0;
                    end
                end
                BK_IND: begin
                    if (cond_ok) begin
                        st_d.taken = 1'b1;
                        st_d.tgt   = {ij_page, idx_val_d};
                        st_d.dly   = br_kind[2];
                    end
                end
                default: st_d = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgt_q   = st_q.tgt;
    assign taken_q = st_q.taken;
    assign delay_q = st_q.dly;
endmodule

// File: rtl/bta_unit_chk.sv
module bta_unit_chk #(
    parameter int AW   = 24,
    parameter int IW   = 16,
    parameter int NIDX = 8,
    localparam int SELW = $clog2(NIDX),
    localparam int PGW  = AW - IW
) (
    input logic               clk,
    input logic               rst_n,
    input logic               br_valid,
    input logic [2:0]         br_kind,
    input logic [PGW-1:0]     ij_page,
    input logic               cond_ok,
    input logic [AW-1:0]      tgt_q,
    input logic               taken_q,
    input logic               delay_q
);
    // R7
    a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !taken_q |-> (tgt_q == '0 && !delay_q));

    // R5
    a_r5_long_undelayed: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind[1:0] == 2'b10) |=> !delay_q);

    // R4
    a_r4_rel16_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind[1:0] == 2'b01) |=> taken_q);

    // R3 R5 R6
    a_r3_cond_false: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind[1:0] != 2'b01 && !cond_ok) |=> !taken_q);

    // R6
    a_r6_page_high: assert property (@(posedge clk) disable iff (!rst_n)
        (br_valid && br_kind[1:0] == 2'b11 && cond_ok) |=>
            (taken_q && tgt_q[AW-1:IW] == $past(ij_page)));

    // R8
    a_r8_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        !br_valid |=> !taken_q);
endmodule

bind bta_unit bta_unit_chk #(.AW(AW), .IW(IW), .NIDX(NIDX)) u_chk (
    .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_kind(br_kind),
    .ij_page(ij_page), .cond_ok(cond_ok), .tgt_q(tgt_q),
    .taken_q(taken_q), .delay_q(delay_q)
);

// File: tb/tb_bta_unit.sv
module tb_bta_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0;
    logic [23:0] br_pc = '0;
    logic [2:0]  br_kind = '0;
    logic [23:0] br_field = '0;
    logic [2:0]  idx_sel = '0;
    logic [127:0] idx_file;
    logic [7:0]  ij_page = '0;
    logic        cond_ok = 1'b0;
    logic [23:0] tgt_q;
    logic        taken_q, delay_q;

    logic [15:0] idx_arr [8];
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always_comb begin
        for (int i = 0; i < 8; i++) idx_file[i*16 +: 16] = idx_arr[i];
    end

    bta_unit dut (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_pc(br_pc),
        .br_kind(br_kind), .br_field(br_field), .idx_sel(idx_sel),
        .idx_file(idx_file), .ij_page(ij_page), .cond_ok(cond_ok),
        .tgt_q(tgt_q), .taken_q(taken_q), .delay_q(delay_q)
    );

    task automatic check(string req, logic [23:0] et, logic ek, logic ed);
        n_run++;
        if (tgt_q !== et || taken_q !== ek || delay_q !== ed) begin
            n_fail++;
            $display("FAIL %s: got tgt=%h taken=%b dly=%b, expected tgt=%h taken=%b dly=%b",
                     req, tgt_q, taken_q, delay_q, et, ek, ed);
        end
    endtask

    // Behavioural reference from the requirements
    task automatic model(output logic [23:0] et, output logic ek, output logic ed,
                         output string req);
        longint off;
        int k;
        et = '0; ek = 1'b0; ed = 1'b0; req = "R8";
        k = int'(br_kind[1:0]);
        if (!br_valid) return;
        if (k == 0) begin
            req = "R3";
            off = longint'(br_field[12:0]);
            if (off >= 4096) off -= 8192;
            if (cond_ok) begin
                ek = 1; ed = br_kind[2];
                et = 24'((longint'(br_pc) + off + 64'd16777216) % 16777216);
            end
        end else if (k == 1) begin
            req = "R4";
            off = longint'(br_field[15:0]);
            if (off >= 32768) off -= 65536;
            ek = 1; ed = br_kind[2];
            et = 24'((longint'(br_pc) + off + 64'd16777216) % 16777216);
        end else if (k == 2) begin
            req = "R5";
            if (cond_ok) begin ek = 1; et = br_field; end
        end else begin
            req = "R6";
            if (cond_ok) begin
                ek = 1; ed = br_kind[2];
                et = {ij_page, idx_arr[idx_sel]};
            end
        end
        if (!ek) req = {req, "/R7"};
    endtask

    task automatic apply(logic v, logic [23:0] pc, logic [2:0] kd, logic [23:0] fld,
                         logic [2:0] sel, logic [7:0] pg, logic c);
        logic [23:0] et; logic ek, ed; string req;
        @(negedge clk);
        br_valid = v; br_pc = pc; br_kind = kd; br_field = fld;
        idx_sel = sel; ij_page = pg; cond_ok = c;
        model(et, ek, ed, req);
        @(posedge clk); #1;
        check({req, " (R2 latency)"}, et, ek, ed);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) idx_arr[i] = 16'h1000 * i[15:0] + 16'h0A5 + i[15:0];
        br_valid = 1'b1; br_kind = 3'b001; cond_ok = 1'b1;
        repeat (3) @(posedge clk);
        #1 check("R1 in reset", '0, 1'b0, 1'b0);
        @(negedge clk); br_valid = 1'b0; rst_n = 1'b1;
        @(posedge clk); #1 check("R1 after release", '0, 1'b0, 1'b0);

        // R3: rel13 forward, backward, wrap below zero, delayed, false
        apply(1, 24'h001000, 3'b000, 24'h000FFF, 0, 0, 1);
        apply(1, 24'h001000, 3'b000, 24'h001000, 0, 0, 1);
        apply(1, 24'h000005, 3'b100, 24'h001FF8, 0, 0, 1);
        apply(1, 24'h123456, 3'b000, 24'h000010, 0, 0, 0);
        // R4: rel16 ignores condition, wrap above top
        apply(1, 24'hFFFFF0, 3'b001, 24'h000020, 0, 0, 0);
        apply(1, 24'h008000, 3'b101, 24'h008000, 0, 0, 1);
        // R5: absolute, delay request dropped, false condition
        apply(1, 24'h000100, 3'b110, 24'hABCDEF, 0, 0, 1);
        apply(1, 24'h000100, 3'b010, 24'h654321, 0, 0, 0);
        // R6: every index register
        for (int s = 0; s < 8; s++)
            apply(1, 24'h000200, {s[0], 2'b11}, 24'h0, s[2:0], 8'h3C + 8'(s), 1);
        apply(1, 24'h000200, 3'b111, 24'h0, 3'd2, 8'h77, 0);
        // R8: invalid with otherwise taken inputs
        apply(0, 24'h000300, 3'b001, 24'h000004, 0, 0, 1);
        apply(0, 24'h000300, 3'b110, 24'h000004, 0, 0, 1);
        // mixed traffic
        for (int n = 0; n < 300; n++)
            apply($urandom_range(0, 7) != 0, 24'($urandom), 3'($urandom),
                  24'($urandom), 3'($urandom), 8'($urandom), 1'($urandom));
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule